// File: doc/BRIEF.md
# I2S to Simultaneous-Load DAC Formatter

This block receives a standard I2S stereo stream of 16-bit two's-complement samples and passes each stereo pair on to a multibit DAC that loads both channels at once. The I2S inputs are sampled by the block's system clock and pass through a synchroniser. Each full left/right pair is checked for a complete slot and converted to offset binary by flipping the sign bit. The pair is then parked in a one-entry holding register.

A transmitter takes the parked pair and shifts the left word and the right word out together, MSB first, on two data lines that share one generated bit clock. It then raises a latch-enable strobe so the DAC commits both words. The DAC's bit clock is derived from the system clock and is independent of the incoming I2S bit clock.

Internally the receiver, the holding slot and the transmitter pass pairs over valid/ready. Neither edge of the block can be stalled: I2S arrives at a fixed rate and the DAC side has no handshake. If a new pair arrives before the transmitter has taken the previous one, the newer pair overwrites the parked pair. At the default parameters the transmitter needs about 80 system clocks per pair, so with the intended rates the newer pair never overwrites an untaken one.

Top module: `i2s_to_simul_dac`

## Requirements
- R1: While reset is asserted and after its release, `dac_bck`, `dac_data_l`, `dac_data_r` and `dac_le` are all 0 until the first pair is sent.
- R2: Input words are taken on rising edges of `i2s_bck`. The left word is carried while `i2s_ws` is 0 and the right word while it is 1. Each word's MSB arrives one bit clock after the `i2s_ws` transition that opens its slot, and each slot is 16 bit clocks long.
- R3: Each output word is the input word with bit 15 inverted. So 0x0000 becomes 0x8000, 0x7FFF becomes 0xFFFF, 0x8000 becomes 0x0000 and 0xFFFF becomes 0x7FFF.
- R4: Both output words are sent together, MSB first, on `dac_data_l` and `dac_data_r`. There are exactly 16 rising edges of `dac_bck` per pair.
- R5: The output data lines change only while `dac_bck` is low, so they hold steady for the whole high phase of every `dac_bck` pulse.
- R6: `dac_le` rises only after the 16th `dac_bck` rising edge of a pair. It stays high for one `dac_bck` period (2×BCK_HALF system clocks) while `dac_bck` is held low, and it is low again before the next pair's first bit.
- R7: After reset, no pair is sent until a full left slot and then a full right slot have been received following an observed `i2s_ws` transition.
- R8: A pair whose left or right slot is not exactly 16 bit clocks long is dropped: it produces no `dac_le` pulse, and the next full pair is sent normally.
- R9: The high phase of `dac_bck` lasts BCK_HALF system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i2s_bck | input | 1 | I2S bit clock, sampled by `clk` |
| i2s_ws | input | 1 | I2S word select, 0 = left, 1 = right |
| i2s_sd | input | 1 | I2S serial data |
| dac_bck | output | 1 | Bit clock shared by both DAC data lines |
| dac_data_l | output | 1 | Left channel serial data, offset binary, MSB first |
| dac_data_r | output | 1 | Right channel serial data, offset binary, MSB first |
| dac_le | output | 1 | Latch enable; its rising edge commits the pair |

## Verification
The bench sends full-scale positive, full-scale negative, zero and minus-one samples, with different words on the two channels. A missing sign flip or swapped channels would show up as a wrong rebuilt word at the latch pulse, and a missing one-bit delay would shift every word by one place. A lead-in frame that starts without a word-select transition must give no latch pulse; a design that released data too early would emit a garbage pair there. A frame with a short left slot must be dropped while the frame after it goes out intact; a design that did not check slot length would latch a misaligned word. The bench also counts bit-clock edges before each latch and measures the latch width, which catches a strobe that comes a bit early or lasts the wrong time.

// File: rtl/dacfmt_pkg.sv
package dacfmt_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_LATCH = 2'd2,
    TX_GAP   = 2'd3
  } tx_state_e;
endpackage

// File: rtl/i2s_word_rx.sv
module i2s_word_rx #(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bck_in,
  input  logic         ws_in,
  input  logic         sd_in,
  output logic         pair_valid,
  output logic [W-1:0] pair_l,
  output logic [W-1:0] pair_r
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] CNT_FULL = CW'(W - 1);
  localparam logic [CW-1:0] CNT_SAT  = '1;
  localparam logic [W-1:0]  SIGN     = {1'b1, {(W-1){1'b0}}};

  logic [SYNC-1:0] s_bck, s_ws, s_sd;
  logic            bck_prev;
  logic            ws_last;
  logic            seen_q;
  logic            left_ok;
  logic [CW-1:0]   cnt;
  logic [W-1:0]    sr;
  logic [W-1:0]    left_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_bck <= '0;
      s_ws  <= '0;
      s_sd  <= '0;
    end else begin
      s_bck <= {s_bck[SYNC-2:0], bck_in};
      s_ws  <= {s_ws[SYNC-2:0], ws_in};
      s_sd  <= {s_sd[SYNC-2:0], sd_in};
    end
  end

  logic         rise;
  logic         ws_now;
  logic [W-1:0] word_now;
  logic         full_slot;

  always_comb begin
    rise      = s_bck[SYNC-1] & ~bck_prev;
    ws_now    = s_ws[SYNC-1];
    word_now  = {sr[W-2:0], s_sd[SYNC-1]};
    full_slot = seen_q && (cnt == CNT_FULL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_prev   <= 1'b0;
      ws_last    <= 1'b0;
      seen_q     <= 1'b0;
      left_ok    <= 1'b0;
      cnt        <= '0;
      sr         <= '0;
      left_hold  <= '0;
      pair_valid <= 1'b0;
      pair_l     <= '0;
      pair_r     <= '0;
    end else begin
      bck_prev   <= s_bck[SYNC-1];
      pair_valid <= 1'b0;
      if (rise) begin
        sr      <= word_now;
        ws_last <= ws_now;
        if (ws_now != ws_last) begin
          seen_q <= 1'b1;
          cnt    <= '0;
          if (!ws_last) begin
            left_hold <= word_now ^ SIGN;
            left_ok   <= full_slot;
          end else begin
            if (left_ok && full_slot) begin
              pair_valid <= 1'b1;
              pair_l     <= left_hold;
              pair_r     <= word_now ^ SIGN;
            end
            left_ok <= 1'b0;
          end
        end else if (cnt != CNT_SAT) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7: no pair before a word-select transition has been seen
  a_r7_pair_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> seen_q);
  // R8: a pair only follows a right slot of exactly W bits
  a_r8_pair_full_slot: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> ($past(cnt) == CNT_FULL));
  // R2: pairs complete only on an input bit-clock rising edge
  a_r2_pair_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $past(rise));
endmodule

// File: rtl/pair_slot.sv
module pair_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_l,
  input  logic [W-1:0] in_r,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_l,
  output logic [W-1:0] out_r
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else if (in_valid) begin
      out_valid <= 1'b1;
      out_l     <= in_l;
      out_r     <= in_r;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: the slot is empty until a pair has been delivered to it
  a_r7_slot_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));
endmodule

// File: rtl/dac_pair_tx.sv
module dac_pair_tx
  import dacfmt_pkg::*;
#(
  parameter int W    = 16,
  parameter int HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_l,
  input  logic [W-1:0] in_r,
  output logic         bck,
  output logic         dl,
  output logic         dr,
  output logic         le
);
  localparam int PW = $clog2(2 * HALF);
  localparam int BW = $clog2(W);
  localparam logic [PW-1:0] PH_MID  = PW'(HALF - 1);
  localparam logic [PW-1:0] PH_LAST = PW'(2 * HALF - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(W - 1);

  tx_state_e    state;
  logic [PW-1:0] ph;
  logic [BW-1:0] bitn;
  logic [W-1:0]  sr_l, sr_r;
  logic          bck_q, le_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      ph    <= '0;
      bitn  <= '0;
      sr_l  <= '0;
      sr_r  <= '0;
      bck_q <= 1'b0;
      le_q  <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (in_valid) begin
            sr_l  <= in_l;
            sr_r  <= in_r;
            ph    <= '0;
            bitn  <= '0;
            state <= TX_SHIFT;
          end
        end
        TX_SHIFT: begin
          ph <= ph + 1'b1;
          if (ph == PH_MID) bck_q <= 1'b1;
          if (ph == PH_LAST) begin
            ph    <= '0;
            bck_q <= 1'b0;
            if (bitn == BIT_LAST) begin
              le_q  <= 1'b1;
              state <= TX_LATCH;
            end else begin
              sr_l <= {sr_l[W-2:0], 1'b0};
              sr_r <= {sr_r[W-2:0], 1'b0};
              bitn <= bitn + 1'b1;
            end
          end
        end
        TX_LATCH: begin
          ph <= ph + 1'b1;
          if (ph == PH_LAST) begin
            ph    <= '0;
            le_q  <= 1'b0;
            state <= TX_GAP;
          end
        end
        default: begin
          ph <= ph + 1'b1;
          if (ph == PH_LAST) begin
            ph    <= '0;
            sr_l  <= '0;
            sr_r  <= '0;
            state <= TX_IDLE;
          end
        end
      endcase
    end
  end

  always_comb begin
    in_ready = (state == TX_IDLE);
    bck      = bck_q;
    le       = le_q;
    dl       = sr_l[W-1];
    dr       = sr_r[W-1];
  end

  // R5: data holds still across the whole high phase of the bit clock
  a_r5_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bck_q && $past(bck_q)) |-> ($stable(sr_l[W-1]) && $stable(sr_r[W-1])));
  // R6: bit clock is parked low while the latch strobe is high
  a_r6_le_bck_low: assert property (@(posedge clk) disable iff (!rst_n)
    le_q |-> !bck_q);
  // R6: strobe rises only after the last bit of the word
  a_r6_le_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(le_q) |-> ($past(bitn) == BIT_LAST));
  // R1: idle transmitter keeps its clock and strobe low
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_IDLE) |-> (!le_q && !bck_q));
endmodule

// File: rtl/i2s_to_simul_dac.sv
module i2s_to_simul_dac #(
  parameter int SAMPLE_W    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int BCK_HALF    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic i2s_bck,
  input  logic i2s_ws,
  input  logic i2s_sd,
  output logic dac_bck,
  output logic dac_data_l,
  output logic dac_data_r,
  output logic dac_le
);
  logic                rx_valid;
  logic [SAMPLE_W-1:0] rx_l, rx_r;
  logic                sl_valid, sl_ready;
  logic [SAMPLE_W-1:0] sl_l, sl_r;

  i2s_word_rx #(.W(SAMPLE_W), .SYNC(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .bck_in(i2s_bck), .ws_in(i2s_ws), .sd_in(i2s_sd),
    .pair_valid(rx_valid), .pair_l(rx_l), .pair_r(rx_r)
  );

  pair_slot #(.W(SAMPLE_W)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_l(rx_l), .in_r(rx_r),
    .out_valid(sl_valid), .out_ready(sl_ready),
    .out_l(sl_l), .out_r(sl_r)
  );

  dac_pair_tx #(.W(SAMPLE_W), .HALF(BCK_HALF)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(sl_valid), .in_ready(sl_ready),
    .in_l(sl_l), .in_r(sl_r),
    .bck(dac_bck), .dl(dac_data_l), .dr(dac_data_r), .le(dac_le)
  );
endmodule

// File: tb/sim_i2s_to_simul_dac.sv
module sim_i2s_to_simul_dac;
  localparam int HALF_OUT = 2;
  localparam int WDOG     = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i2s_bck = 1'b0, i2s_ws = 1'b0, i2s_sd = 1'b0;
  logic dac_bck, dac_data_l, dac_data_r, dac_le;

  always #2 clk = ~clk;

  i2s_to_simul_dac #(.SAMPLE_W(16), .SYNC_STAGES(2), .BCK_HALF(HALF_OUT)) u0 (
    .clk(clk), .rst_n(rst_n),
    .i2s_bck(i2s_bck), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd),
    .dac_bck(dac_bck), .dac_data_l(dac_data_l), .dac_data_r(dac_data_r),
    .dac_le(dac_le)
  );

  int nchk = 0, nerr = 0, cyc = 0, le_pulses = 0;
  logic [15:0] exp_l[$], exp_r[$];
  logic        prev_lsb = 1'b0;
  logic        slot_open = 1'b0;
  logic        mon_on = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] ob(input logic [15:0] x);
    return {~x[15], x[14:0]};
  endfunction

  // output monitor, sampled on the falling system clock
  logic        bck_p = 1'b0, le_p = 1'b0;
  logic [15:0] cap_l = '0, cap_r = '0;
  int          nbits = 0, le_len = 0, hi_len = 0;
  logic        hold_l = 1'b0, hold_r = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (dac_bck && !bck_p) begin
        cap_l  = {cap_l[14:0], dac_data_l};
        cap_r  = {cap_r[14:0], dac_data_r};
        hold_l = dac_data_l;
        hold_r = dac_data_r;
        nbits++;
        hi_len = 1;
      end else if (dac_bck && bck_p) begin
        hi_len++;
        check(dac_data_l == hold_l && dac_data_r == hold_r, "R5",
              "data moved while bck high", {dac_data_l, dac_data_r}, {hold_l, hold_r});
      end else if (!dac_bck && bck_p) begin
        check(hi_len == HALF_OUT, "R9", "bck high length", hi_len, HALF_OUT);
      end
      if (dac_le && !le_p) begin
        le_pulses++;
        le_len = 1;
        check(nbits == 16, "R4", "bck edges before latch", nbits, 16);
        check(!dac_bck, "R6", "bck low at latch", dac_bck, 0);
        if (exp_l.size() == 0) begin
          check(1'b0, "R7", "unexpected latch pulse", {cap_l, cap_r}, 0);
        end else begin
          logic [15:0] el, er;
          el = exp_l.pop_front();
          er = exp_r.pop_front();
          check(cap_l == el, "R3", "left word", cap_l, el);
          check(cap_r == er, "R3", "right word", cap_r, er);
        end
        nbits = 0;
      end else if (dac_le && le_p) begin
        le_len++;
        check(!dac_bck, "R6", "bck low during latch", dac_bck, 0);
      end else if (!dac_le && le_p) begin
        check(le_len == 2 * HALF_OUT, "R6", "latch width", le_len, 2 * HALF_OUT);
      end
      bck_p = dac_bck;
      le_p  = dac_le;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic drive_bit(input logic ws, input logic sd);
    i2s_bck = 1'b0;
    i2s_ws  = ws;
    i2s_sd  = sd;
    repeat (8) @(negedge clk);
    i2s_bck = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // R2: left slot of llen clocks with ws=0, right slot of 16 with ws=1,
  // MSB one clock after each ws change.
  task automatic send_frame(input logic [15:0] l, input logic [15:0] r,
                            input int llen, input bit expect_out);
    if (!slot_open) drive_bit(1'b0, prev_lsb);
    slot_open = 1'b0;
    for (int i = 1; i < llen; i++) drive_bit(1'b0, l[16-i]);
    drive_bit(1'b1, l[16-llen]);
    for (int i = 0; i < 15; i++) drive_bit(1'b1, r[15-i]);
    prev_lsb = r[0];
    if (expect_out && llen == 16) begin
      exp_l.push_back(ob(l));
      exp_r.push_back(ob(r));
    end
  endtask

  task automatic flush();
    drive_bit(1'b0, prev_lsb);
    slot_open = 1'b1;
    repeat (200) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check({dac_bck, dac_data_l, dac_data_r, dac_le} == 4'b0, "R1",
          "outputs in reset", {dac_bck, dac_data_l, dac_data_r, dac_le}, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (5) @(negedge clk);
    check({dac_bck, dac_data_l, dac_data_r, dac_le} == 4'b0, "R1",
          "outputs after reset", {dac_bck, dac_data_l, dac_data_r, dac_le}, 0);
  endtask

  task automatic t_startup();
    int base;
    base = le_pulses;
    send_frame(16'h5A5A, 16'hC3C3, 16, 1'b0);
    flush();
    check(le_pulses == base, "R7", "no pair before sync", le_pulses - base, 0);
  endtask

  task automatic t_values();
    int base;
    base = le_pulses;
    send_frame(16'h7FFF, 16'h8000, 16, 1'b1);
    send_frame(16'h0000, 16'hFFFF, 16, 1'b1);
    send_frame(16'h8000, 16'h7FFF, 16, 1'b1);
    send_frame(16'h1234, 16'hA5C3, 16, 1'b1);
    flush();
    check(le_pulses == base + 4, "R2", "pairs emitted", le_pulses - base, 4);
    check(exp_l.size() == 0, "R4", "pairs outstanding", exp_l.size(), 0);
  endtask

  task automatic t_short_slot();
    int base;
    base = le_pulses;
    send_frame(16'hDEAD, 16'hBEEF, 8, 1'b0);
    send_frame(16'h0001, 16'hFFFE, 16, 1'b1);
    flush();
    check(le_pulses == base + 1, "R8", "short slot dropped", le_pulses - base, 1);
    check(exp_l.size() == 0, "R8", "pair after short slot", exp_l.size(), 0);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_values();
    t_short_slot();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule